// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the received data for one OUT endpoint of a USB device. A packet engine on the bus side sends each packet as a start strobe, a series of byte strobes and an end strobe that carries a good/bad verdict. The block stores the accepted packets in a byte ring and answers the engine with a one-cycle ACK or NAK pulse. The CPU side reads the packet at the head of the ring one byte at a time through a pop port. The byte count of that packet is shown on a length output.

The block can hold one packet or two. It holds two only when the double-buffer disable bit is clear and the ring is at least twice the configured maximum packet size. The ready flag, the full flag and the endpoint interrupt behave differently in the two modes. A packet is released when software writes a clear, or automatically after its last byte is popped if the packet was exactly the maximum size. A released slot lets the next packet be acknowledged. While no slot is free, incoming packets are answered with NAK and their data is thrown away. A packet that ends bad, or that is longer than the maximum, is rolled back without any handshake.

Top module: `usb_out_rxbuf`

## Requirements
- R1: After reset, rx_ready, rx_full and ep_irq are 0. The readback outputs show cfg_dbl_dis=1, cfg_auto_clr=0 and cfg_maxp=64.
- R2: A cycle with ctl_we high loads ctl_maxp, ctl_auto_clr and ctl_dbl_dis into the configuration. If ctl_maxp is above 64 (the ring depth), the maximum-size field keeps its old value.
- R3: Two-packet mode is active only when cfg_dbl_dis=0 and 2*cfg_maxp <= 64. Otherwise the block holds one packet and NAKs a second packet.
- R4: In one-packet mode, an accepted packet sets both rx_ready and rx_full. In the cycle after the end strobe it gives a one-cycle hs_ack pulse and a one-cycle ep_irq pulse.
- R5: In two-packet mode, the first packet sets rx_ready only and pulses ep_irq. A second packet accepted while the first is pending sets rx_full and does not pulse ep_irq.
- R6: A packet that starts while no slot is free is discarded and gives an hs_nak pulse in the cycle after its end strobe. The flags, rx_len and the stored data stay unchanged.
- R7: A high sw_clr_rdy while rx_ready is high releases the head packet. If another packet is queued, rx_ready and rx_full read 0 for one cycle. In the next cycle rx_ready returns to 1 for the queued packet, with an ep_irq pulse.
- R8: With cfg_auto_clr=1, popping the last byte of a head packet whose length equals cfg_maxp releases that packet, as in R7. A shorter packet stays until sw_clr_rdy is written.
- R9: A packet that ends with pk_good=0, or that carries more than cfg_maxp bytes, is not stored. It gets no hs_ack and no hs_nak, changes no flag, and leaves the data of later packets intact.
- R10: pop_data shows the next byte of the head packet, and a pop advances to the byte after it. rx_len gives the head packet's byte count. Packets are read in arrival order. A release before every byte has been popped skips the bytes that were left.
- R11: A pop while rx_ready is 0, or after every byte of the head packet has been popped, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_we | input | 1 | Configuration write strobe |
| ctl_maxp | input | 7 | Maximum packet size to load |
| ctl_auto_clr | input | 1 | Auto-clear enable to load |
| ctl_dbl_dis | input | 1 | Double-buffer disable to load |
| sw_clr_rdy | input | 1 | Software clear of rx_ready (releases the head packet) |
| pk_start | input | 1 | Packet start strobe from the packet engine |
| pk_valid | input | 1 | Data byte strobe |
| pk_data | input | 8 | Data byte |
| pk_end | input | 1 | Packet end strobe (carries no data byte) |
| pk_good | input | 1 | Packet verdict, sampled with pk_end |
| hs_ack | output | 1 | One-cycle ACK pulse to the packet engine |
| hs_nak | output | 1 | One-cycle NAK pulse to the packet engine |
| pop | input | 1 | CPU pop of one byte of the head packet |
| pop_data | output | 8 | Current byte of the head packet |
| rx_len | output | 7 | Byte count of the head packet |
| rx_ready | output | 1 | A packet is ready to read |
| rx_full | output | 1 | Every slot is taken |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |
| cfg_maxp | output | 7 | Readback of the maximum packet size |
| cfg_auto_clr | output | 1 | Readback of auto-clear |
| cfg_dbl_dis | output | 1 | Readback of double-buffer disable |

## Verification
A wrong pending count or head pointer shows up on the next handshake or the next pop. An extra count turns the next ACK into a NAK. A lost count sets rx_ready low while bytes still wait. A bad read base makes the very next pop_data differ from the stream the bench sent. A faulty re-queue step is visible in the two cycles right after a release: the one-cycle drop of rx_ready and rx_full, followed by the interrupt pulse. A rollback fault shows up only when the following good packet is popped, as corrupted bytes. The bench therefore always reads every accepted packet back and compares it with the bytes it sent.

// File: rtl/usb_rxbuf_pkg.sv
package usb_rxbuf_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_STORE = 2'd1,
    WR_DROP  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/rxbuf_wr.sv
module rxbuf_wr
  import usb_rxbuf_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pk_start,
  input  logic          pk_valid,
  input  logic [DW-1:0] pk_data,
  input  logic          pk_end,
  input  logic          pk_good,
  input  logic          slot_free,
  input  logic [LW-1:0] maxp,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          commit,
  output logic [LW-1:0] commit_len,
  output logic          ack,
  output logic          nak
);
  wr_state_e     st_q, st_d;
  logic [AW-1:0] base_q, base_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          ack_q, ack_d, nak_q, nak_d;

  assign mem_addr   = base_q + AW'(cnt_q);
  assign mem_wdata  = pk_data;
  assign commit_len = cnt_q;
  assign ack        = ack_q;
  assign nak        = nak_q;

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    ack_d  = 1'b0;
    nak_d  = 1'b0;
    mem_we = 1'b0;
    commit = 1'b0;
    if (pk_start) begin
      st_d  = slot_free ? WR_STORE : WR_DROP;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      unique case (st_q)
        WR_STORE: begin
          if (pk_end) begin
            st_d = WR_IDLE;
            if (pk_good && !ovf_q) begin
              commit = 1'b1;
              ack_d  = 1'b1;
              base_d = base_q + AW'(cnt_q);
            end
          end else if (pk_valid) begin
            if (cnt_q < maxp) begin
              mem_we = 1'b1;
              cnt_d  = cnt_q + LW'(1);
            end else begin
              ovf_d = 1'b1;
            end
          end
        end
        WR_DROP: begin
          if (pk_end) begin
            st_d  = WR_IDLE;
            nak_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      ack_q  <= 1'b0;
      nak_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      ack_q  <= ack_d;
      nak_q  <= nak_d;
    end
  end

  // R6 R4
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ack_q && nak_q));
  // R9
  store_len_chk: assert property (@(posedge clk) disable iff (!rst_n) commit |-> (commit_len <= maxp));
endmodule

// File: rtl/rxbuf_slots.sv
module rxbuf_slots #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl,
  input  logic          auto_clr,
  input  logic [LW-1:0] maxp,
  input  logic          commit,
  input  logic [LW-1:0] commit_len,
  input  logic          pop,
  input  logic          sw_clr,
  output logic          slot_free,
  output logic          rdy,
  output logic          full,
  output logic [LW-1:0] head_len,
  output logic [AW-1:0] rd_addr,
  output logic          irq
);
  logic [1:0]    pend_q, pend_d;
  logic          gap_q, gap_d;
  logic          irq_q, irq_d;
  logic [AW-1:0] rbase_q, rbase_d;
  logic [LW-1:0] pcnt_q, pcnt_d;
  logic [LW-1:0] len_q [2];
  logic [LW-1:0] len_d [2];
  logic          pop_ok, auto_rel, rel;
  logic [1:0]    widx;

  assign rdy       = (pend_q != 2'd0) && !gap_q;
  assign full      = dbl ? (pend_q == 2'd2) : ((pend_q != 2'd0) && !gap_q);
  assign slot_free = dbl ? (pend_q < 2'd2) : (pend_q == 2'd0);
  assign head_len  = len_q[0];
  assign rd_addr   = rbase_q + AW'(pcnt_q);
  assign irq       = irq_q;

  assign pop_ok   = pop && rdy && (pcnt_q < len_q[0]);
  assign auto_rel = pop_ok && auto_clr && (len_q[0] == maxp) && ((pcnt_q + LW'(1)) == len_q[0]);
  assign rel      = rdy && (sw_clr || auto_rel);
  assign widx     = pend_q - {1'b0, rel};

  always_comb begin
    len_d  = len_q;
    pend_d = pend_q - {1'b0, rel} + {1'b0, commit};
    if (rel) len_d[0] = len_q[1];
    if (commit) len_d[widx[0]] = commit_len;
    rbase_d = rel ? (rbase_q + AW'(len_q[0])) : rbase_q;
    pcnt_d  = rel ? '0 : (pcnt_q + {{(LW-1){1'b0}}, pop_ok});
    gap_d   = rel && (pend_d != 2'd0);
    irq_d   = (commit && (pend_q == 2'd0)) || gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 2'd0;
      gap_q   <= 1'b0;
      irq_q   <= 1'b0;
      rbase_q <= '0;
      pcnt_q  <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      pend_q  <= pend_d;
      gap_q   <= gap_d;
      irq_q   <= irq_d;
      rbase_q <= rbase_d;
      pcnt_q  <= pcnt_d;
      if (rel || commit) begin
        len_q[0] <= len_d[0];
        len_q[1] <= len_d[1];
      end
    end
  end

  // R3 R6
  commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n) commit |-> (pend_q != 2'd2));
  // R7
  requeue_chk: assert property (@(posedge clk) disable iff (!rst_n) gap_q |=> (rdy && irq_q));
  // R11
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) pcnt_q <= len_q[0]);
endmodule

// File: rtl/usb_out_rxbuf.sv
module usb_out_rxbuf #(
  parameter int DW = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [LW-1:0] ctl_maxp,
  input  logic          ctl_auto_clr,
  input  logic          ctl_dbl_dis,
  input  logic          sw_clr_rdy,
  input  logic          pk_start,
  input  logic          pk_valid,
  input  logic [DW-1:0] pk_data,
  input  logic          pk_end,
  input  logic          pk_good,
  output logic          hs_ack,
  output logic          hs_nak,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] rx_len,
  output logic          rx_ready,
  output logic          rx_full,
  output logic          ep_irq,
  output logic [LW-1:0] cfg_maxp,
  output logic          cfg_auto_clr,
  output logic          cfg_dbl_dis
);
  logic [1:0]    rsync_q;
  logic          rst_s;
  logic [LW-1:0] maxp_q;
  logic          auto_q, dis_q;
  logic          maxp_ok, dbl;
  logic [LW:0]   twice_maxp;
  logic          slot_free, commit, mem_we;
  logic [LW-1:0] commit_len;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  assign maxp_ok    = (ctl_maxp <= LW'(DEPTH));
  assign twice_maxp = {maxp_q, 1'b0};
  assign dbl        = !dis_q && (twice_maxp <= (LW+1)'(DEPTH));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      maxp_q <= LW'(DEPTH);
      auto_q <= 1'b0;
      dis_q  <= 1'b1;
    end else if (ctl_we) begin
      auto_q <= ctl_auto_clr;
      dis_q  <= ctl_dbl_dis;
      if (maxp_ok) maxp_q <= ctl_maxp;
    end
  end

  assign cfg_maxp     = maxp_q;
  assign cfg_auto_clr = auto_q;
  assign cfg_dbl_dis  = dis_q;

  rxbuf_wr #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_s),
    .pk_start(pk_start), .pk_valid(pk_valid), .pk_data(pk_data),
    .pk_end(pk_end), .pk_good(pk_good),
    .slot_free(slot_free), .maxp(maxp_q),
    .mem_we(mem_we), .mem_addr(waddr), .mem_wdata(wdata),
    .commit(commit), .commit_len(commit_len),
    .ack(hs_ack), .nak(hs_nak)
  );

  rxbuf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(pop_data)
  );

  rxbuf_slots #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_s),
    .dbl(dbl), .auto_clr(auto_q), .maxp(maxp_q),
    .commit(commit), .commit_len(commit_len),
    .pop(pop), .sw_clr(sw_clr_rdy),
    .slot_free(slot_free), .rdy(rx_ready), .full(rx_full),
    .head_len(rx_len), .rd_addr(raddr), .irq(ep_irq)
  );

  // R2
  maxp_legal_chk: assert property (@(posedge clk) disable iff (!rst_s) maxp_q <= LW'(DEPTH));
  // R4
  ack_flag_chk: assert property (@(posedge clk) disable iff (!rst_s) hs_ack |-> rx_ready || rx_full || !rsync_q[1]);
endmodule

// File: tb/sim_usb_out_rxbuf.sv
`timescale 1ns/1ps
module sim_usb_out_rxbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_auto_clr = 0, ctl_dbl_dis = 0, sw_clr_rdy = 0;
  logic [6:0] ctl_maxp = '0;
  logic pk_start = 0, pk_valid = 0, pk_end = 0, pk_good = 0, pop = 0;
  logic [7:0] pk_data = '0;
  logic hs_ack, hs_nak, rx_ready, rx_full, ep_irq, cfg_auto_clr, cfg_dbl_dis;
  logic [7:0] pop_data;
  logic [6:0] rx_len, cfg_maxp;

  int n_tests = 0, n_fail = 0;
  int m_maxp = 64;
  bit m_auto = 0, m_dis = 1;
  int ql[$];
  logic [7:0] qb[$];
  int pc = 0;

  always #10 clk = ~clk;

  usb_out_rxbuf u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_maxp(ctl_maxp),
    .ctl_auto_clr(ctl_auto_clr), .ctl_dbl_dis(ctl_dbl_dis), .sw_clr_rdy(sw_clr_rdy),
    .pk_start(pk_start), .pk_valid(pk_valid), .pk_data(pk_data), .pk_end(pk_end),
    .pk_good(pk_good), .hs_ack(hs_ack), .hs_nak(hs_nak), .pop(pop), .pop_data(pop_data),
    .rx_len(rx_len), .rx_ready(rx_ready), .rx_full(rx_full), .ep_irq(ep_irq),
    .cfg_maxp(cfg_maxp), .cfg_auto_clr(cfg_auto_clr), .cfg_dbl_dis(cfg_dbl_dis)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cap();
    return (m_dis || (2 * m_maxp > 64)) ? 1 : 2;
  endfunction

  function automatic int exp_full();
    return (cap() == 1) ? int'(ql.size() > 0) : int'(ql.size() == 2);
  endfunction

  task automatic check_flags(input string req);
    chk({req, " rx_ready"}, int'(rx_ready), int'(ql.size() > 0));
    chk({req, " rx_full"}, int'(rx_full), exp_full());
    if (ql.size() > 0) chk({req, " rx_len"}, int'(rx_len), ql[0]);
  endtask

  task automatic cfg(input int maxp, input bit au, input bit dis);
    @(negedge clk);
    ctl_we = 1; ctl_maxp = 7'(maxp); ctl_auto_clr = au; ctl_dbl_dis = dis;
    @(negedge clk);
    ctl_we = 0;
    if (maxp <= 64) m_maxp = maxp;
    m_auto = au; m_dis = dis;
    chk("R2 maxp", int'(cfg_maxp), m_maxp);
    chk("R2 auto", int'(cfg_auto_clr), int'(m_auto));
    chk("R2 dis", int'(cfg_dbl_dis), int'(m_dis));
  endtask

  task automatic send(input int len, input bit good);
    logic [7:0] b [$];
    bit busy, was_empty, exp_ack;
    busy = (ql.size() >= cap());
    was_empty = (ql.size() == 0);
    exp_ack = !busy && good && (len <= m_maxp);
    @(negedge clk);
    pk_start = 1;
    @(negedge clk);
    pk_start = 0;
    for (int i = 0; i < len; i++) begin
      pk_valid = 1;
      pk_data = 8'($urandom);
      b.push_back(pk_data);
      @(negedge clk);
    end
    pk_valid = 0; pk_end = 1; pk_good = good;
    @(negedge clk);
    pk_end = 0; pk_good = 0;
    chk("R4 R9 hs_ack", int'(hs_ack), int'(exp_ack));
    chk("R6 hs_nak", int'(hs_nak), int'(busy));
    if (exp_ack) begin
      ql.push_back(len);
      foreach (b[i]) qb.push_back(b[i]);
    end
    chk("R4 R5 ep_irq", int'(ep_irq), int'(exp_ack && was_empty));
    check_flags("R5 R6");
  endtask

  task automatic release_model();
    for (int i = 0; i < ql[0]; i++) void'(qb.pop_front());
    void'(ql.pop_front());
    pc = 0;
  endtask

  task automatic settle_after_release();
    if (ql.size() > 0) begin
      chk("R7 gap rx_ready", int'(rx_ready), 0);
      chk("R7 gap rx_full", int'(rx_full), 0);
      @(negedge clk);
      chk("R7 requeue rx_ready", int'(rx_ready), 1);
      chk("R7 requeue ep_irq", int'(ep_irq), 1);
    end
    check_flags("R7");
  endtask

  task automatic pop_one();
    chk("R10 pop_data", int'(pop_data), int'(qb[pc]));
    chk("R10 rx_len", int'(rx_len), ql[0]);
    pop = 1;
    @(negedge clk);
    pop = 0;
    pc++;
    if (m_auto && ql[0] == m_maxp && pc == ql[0]) begin
      release_model();
      settle_after_release();
    end else begin
      check_flags("R8");
    end
  endtask

  task automatic pop_n(input int n);
    for (int k = 0; k < n; k++) begin
      if (ql.size() == 0 || pc >= ql[0]) break;
      pop_one();
    end
  endtask

  task automatic sw_clear();
    @(negedge clk);
    sw_clr_rdy = 1;
    @(negedge clk);
    sw_clr_rdy = 0;
    if (ql.size() > 0) begin
      release_model();
      settle_after_release();
    end else begin
      check_flags("R7 idle clear");
    end
  endtask

  task automatic drain();
    while (ql.size() > 0) sw_clear();
  endtask

  task automatic rand_phase(input int iters);
    for (int it = 0; it < iters; it++) begin
      int r;
      r = $urandom % 5;
      if (r < 2) send($urandom % (m_maxp + 2), ($urandom % 8) != 0);
      else if (r < 4) begin
        if (ql.size() > 0) pop_n(1 + $urandom % (ql[0] + 1));
      end else sw_clear();
    end
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", int'(rx_ready), 0);
    chk("R1 rx_full", int'(rx_full), 0);
    chk("R1 ep_irq", int'(ep_irq), 0);
    chk("R1 dbl_dis", int'(cfg_dbl_dis), 1);
    chk("R1 auto_clr", int'(cfg_auto_clr), 0);
    chk("R1 maxp", int'(cfg_maxp), 64);

    // R4 single mode, R6 NAK, R10 skip remainder
    send(5, 1);
    send(3, 1);
    pop_n(2);
    sw_clear();
    send(4, 1);
    pop_n(4);
    sw_clear();

    // R5 double mode, R8 auto clear
    cfg(8, 1, 0);
    send(8, 1);
    send(3, 1);
    send(2, 1);
    pop_n(8);
    pop_n(3);
    chk("R8 short stays", int'(rx_ready), 1);
    sw_clear();

    // R11 pop ignored while empty
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    send(2, 1);
    pop_n(2);
    // R11 pop beyond end ignored
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    chk("R11 rx_ready held", int'(rx_ready), 1);
    sw_clear();

    // R9 rollback of bad and overlength packets
    send(5, 0);
    send(9, 1);
    send(6, 1);
    pop_n(6);
    sw_clear();

    // R3 double disallowed when maxp too large
    cfg(40, 0, 0);
    send(2, 1);
    send(2, 1);
    drain();
    // R2 rejected maxp
    cfg(70, 0, 0);
    send(41, 1);
    chk("R2 rejected maxp keeps 40", int'(cfg_maxp), 40);

    cfg(16, 1, 0);
    rand_phase(250);
    cfg(12, 0, 1);
    rand_phase(200);
    cfg(32, 1, 0);
    rand_phase(150);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule